// File: doc/BRIEF.md
# Flagged Subtract and Clamp ALU Slice

This block is a 32-bit arithmetic slice with a registered result and three registered condition flags (negative, zero, carry). On each cycle where the valid strobe is high, a 2-bit operation code selects one of four functions applied to a destination operand and a source operand. The result and the flags are captured at the clock edge. When the strobe is low, all state holds.

Subtraction is built as an addition. The source operand is inverted, and the incoming carry is also inverted before it enters the adder as the carry-in. The adder's carry-out is inverted once more before it is stored, so a set carry flag always means a borrow was taken. The subtract-with-carry function draws its incoming borrow from a dedicated carry input. The plain subtract forces that incoming borrow to zero.

The clamp function treats the destination operand as signed and limits it to the unsigned 16-bit range. Like the pass-through function, it updates only the negative and zero flags and leaves the carry flag as it was.

Top module: `flag_alu`

## Requirements
- R1: With `in_op` = 2'b01 (subtract with carry), the result is the low 32 bits of `in_rn` + ~`in_rm` + ~`in_carry`. This equals `in_rn` − `in_rm` − `in_carry` modulo 2^32.
- R2: After either subtract (`in_op` 2'b01 or 2'b10), `out_c` is the inverted bit 32 of the 33-bit sum. It is 1 exactly when `in_rm` plus the incoming borrow exceeds `in_rn` as unsigned numbers.
- R3: With `in_op` = 2'b10 (plain subtract), the incoming borrow is taken as 0 whatever `in_carry` is. The result is `in_rn` − `in_rm` modulo 2^32.
- R4: After every accepted operation, `out_z` is 1 exactly when `out_result` is zero, and `out_n` equals `out_result` bit 31.
- R5: With `in_op` = 2'b11 (clamp), `in_rn` is read as signed. A negative value gives 0, a value above 0x0000FFFF gives 0x0000FFFF, and any other value passes unchanged.
- R6: The clamp (2'b11) and pass-through (2'b00) operations leave `out_c` unchanged.
- R7: With `in_op` = 2'b00 (pass-through), the result is `in_rn`.
- R8: In a cycle with `in_valid` low, `out_result`, `out_n`, `out_z` and `out_c` keep their values.
- R9: A synchronous active-high `rst` clears the result and all three flags at the next edge. It takes priority over `in_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Accept strobe; the operation executes when high |
| in_op | input | 2 | 00 pass, 01 subtract with carry, 10 subtract, 11 clamp to 16 bits |
| in_rn | input | 32 | Destination operand (minuend, clamp and pass input) |
| in_rm | input | 32 | Source operand (subtrahend) |
| in_carry | input | 1 | Incoming borrow for subtract with carry |
| out_result | output | 32 | Registered result |
| out_n | output | 1 | Negative flag |
| out_z | output | 1 | Zero flag |
| out_c | output | 1 | Carry flag; set means a borrow occurred |

## Verification
Reset and an accepted operation can arrive in the same cycle. The random stream raises reset at random while valid and the other inputs keep changing, and in that cycle the registers must clear rather than load. A borrow-in and an adder wrap can also meet in the same subtraction. Directed cases provoke this with 0 − 0 and 0xFFFFFFFF − 0xFFFFFFFF with borrow-in set, which must give 0xFFFFFFFF with the carry flag set. Results are judged against a bench model that computes plain subtraction with an unsigned comparison, not the inverted-carry addition the design uses.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;
  typedef enum logic [1:0] {
    OP_PASS  = 2'b00,
    OP_SUBC  = 2'b01,
    OP_SUB   = 2'b10,
    OP_CLAMP = 2'b11
  } alu_op_e;
endpackage

// File: rtl/flag_alu_sub.sv
module flag_alu_sub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         borrow_in,
  output logic [W-1:0] diff,
  output logic         borrow_out
);
  localparam int SUM_W = W + 1;

  // Subtraction as addition: invert operand and carry-in.
  function automatic logic [SUM_W-1:0] inv_add(input logic [W-1:0] x,
                                                input logic [W-1:0] y,
                                                input logic         bin);
    return {1'b0, x} + {1'b0, ~y} + {{W{1'b0}}, ~bin};
  endfunction

  logic [SUM_W-1:0] sum;

  always_comb begin
    sum        = inv_add(a, b, borrow_in);
    diff       = sum[W-1:0];
    borrow_out = ~sum[W];
  end
endmodule

// File: rtl/flag_alu_clamp.sv
module flag_alu_clamp #(
  parameter int W        = 32,
  parameter int SAT_BITS = 16
) (
  input  logic [W-1:0] val,
  output logic [W-1:0] clamped
);
  localparam logic [W-1:0] LIMIT = {{(W-SAT_BITS){1'b0}}, {SAT_BITS{1'b1}}};

  function automatic logic [W-1:0] clamp_u(input logic [W-1:0] v);
    if (v[W-1])
      return '0;
    else if (|v[W-2:SAT_BITS])
      return LIMIT;
    else
      return v;
  endfunction

  always_comb clamped = clamp_u(val);
endmodule

// File: rtl/flag_alu_state.sv
module flag_alu_state #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] nxt_result,
  input  logic         nxt_c,
  output logic [W-1:0] result,
  output logic         flag_n,
  output logic         flag_z,
  output logic         flag_c
);
  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      flag_n <= 1'b0;
      flag_z <= 1'b0;
      flag_c <= 1'b0;
    end else if (load) begin
      result <= nxt_result;
      flag_n <= nxt_result[W-1];
      flag_z <= (nxt_result == '0);
      flag_c <= nxt_c;
    end
  end
endmodule

// File: rtl/flag_alu.sv
module flag_alu #(
  parameter int W        = 32,
  parameter int SAT_BITS = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [1:0]   in_op,
  input  logic [W-1:0] in_rn,
  input  logic [W-1:0] in_rm,
  input  logic         in_carry,
  output logic [W-1:0] out_result,
  output logic         out_n,
  output logic         out_z,
  output logic         out_c
);
  import flag_alu_pkg::*;

  alu_op_e      op;
  logic         w_borrow_in;
  logic [W-1:0] w_diff;
  logic         w_borrow;
  logic [W-1:0] w_clamped;
  logic [W-1:0] w_nxt_result;
  logic         w_nxt_c;

  assign op          = alu_op_e'(in_op);
  assign w_borrow_in = (op == OP_SUBC) ? in_carry : 1'b0;

  flag_alu_sub #(.W(W)) u_sub (
    .a         (in_rn),
    .b         (in_rm),
    .borrow_in (w_borrow_in),
    .diff      (w_diff),
    .borrow_out(w_borrow)
  );

  flag_alu_clamp #(.W(W), .SAT_BITS(SAT_BITS)) u_clamp (
    .val    (in_rn),
    .clamped(w_clamped)
  );

  always_comb begin
    unique case (op)
      OP_SUBC, OP_SUB: begin
        w_nxt_result = w_diff;
        w_nxt_c      = w_borrow;
      end
      OP_CLAMP: begin
        w_nxt_result = w_clamped;
        w_nxt_c      = out_c;
      end
      default: begin
        w_nxt_result = in_rn;
        w_nxt_c      = out_c;
      end
    endcase
  end

  flag_alu_state #(.W(W)) u_state (
    .clk       (clk),
    .rst       (rst),
    .load      (in_valid),
    .nxt_result(w_nxt_result),
    .nxt_c     (w_nxt_c),
    .result    (out_result),
    .flag_n    (out_n),
    .flag_z    (out_z),
    .flag_c    (out_c)
  );
endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk #(
  parameter int W        = 32,
  parameter int SAT_BITS = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [1:0]   in_op,
  input logic [W-1:0] in_rn,
  input logic [W-1:0] in_rm,
  input logic         in_carry,
  input logic [W-1:0] out_result,
  input logic         out_n,
  input logic         out_z,
  input logic         out_c,
  input logic         w_borrow_in
);
  localparam logic [W-1:0] LIMIT = {{(W-SAT_BITS){1'b0}}, {SAT_BITS{1'b1}}};

  assert_subc_value_R1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 2'b01) |=>
      out_result == $past(in_rn) - $past(in_rm) - W'($past(in_carry)));

  assert_borrow_flag_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op[1] != in_op[0]) |=>
      out_c == (({1'b0, $past(in_rm)} + (W+1)'($past(w_borrow_in))) > {1'b0, $past(in_rn)}));

  assert_sub_plain_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 2'b10) |=> out_result == $past(in_rn) - $past(in_rm));

  assert_flags_R4: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_z == (out_result == '0)) && (out_n == out_result[W-1]));

  assert_clamp_range_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 2'b11) |=> out_result <= LIMIT);

  assert_keep_carry_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op[1] == in_op[0]) |=> out_c == $past(out_c));

  assert_pass_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 2'b00) |=> out_result == $past(in_rn));

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_result) && $stable(out_n) && $stable(out_z) && $stable(out_c));

  assert_reset_R9: assert property (@(posedge clk)
    rst |=> out_result == '0 && !out_n && !out_z && !out_c);
endmodule

bind flag_alu flag_alu_chk #(.W(W), .SAT_BITS(SAT_BITS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_op      (in_op),
  .in_rn      (in_rn),
  .in_rm      (in_rm),
  .in_carry   (in_carry),
  .out_result (out_result),
  .out_n      (out_n),
  .out_z      (out_z),
  .out_c      (out_c),
  .w_borrow_in(w_borrow_in)
);

// File: tb/test_flag_alu.sv
`timescale 1ns/1ps
module test_flag_alu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  in_op = 2'b00;
  logic [31:0] in_rn = '0;
  logic [31:0] in_rm = '0;
  logic        in_carry = 1'b0;
  logic [31:0] out_result;
  logic        out_n, out_z, out_c;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Model state
  logic [31:0] m_res = '0;
  logic        m_n = 0, m_z = 0, m_c = 0;

  always #4 clk = ~clk;

  flag_alu i_flag_alu (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .in_rn(in_rn), .in_rm(in_rm), .in_carry(in_carry),
    .out_result(out_result), .out_n(out_n), .out_z(out_z), .out_c(out_c)
  );

  function automatic logic [31:0] exp_clamp(input logic [31:0] v);
    if ($signed(v) < 0) return 32'h0;
    if (v > 32'h0000FFFF) return 32'h0000FFFF;
    return v;
  endfunction

  function automatic logic exp_borrow(input logic [31:0] a, input logic [31:0] b,
                                      input logic bin);
    return ({1'b0, b} + {32'b0, bin}) > {1'b0, a};
  endfunction

  function automatic string tag_of(input logic r, input logic v, input logic [1:0] op);
    if (r) return "R9";
    if (!v) return "R8";
    case (op)
      2'b00: return "R7,R6,R4";
      2'b01: return "R1,R2,R4";
      2'b10: return "R3,R2,R4";
      default: return "R5,R6,R4";
    endcase
  endfunction

  task automatic step(input logic r, input logic v, input logic [1:0] op,
                      input logic [31:0] rn, input logic [31:0] rm, input logic cin);
    string tag;
    rst = r; in_valid = v; in_op = op; in_rn = rn; in_rm = rm; in_carry = cin;
    tag = tag_of(r, v, op);
    if (r) begin
      m_res = '0; m_n = 0; m_z = 0; m_c = 0;
    end else if (v) begin
      case (op)
        2'b01: begin m_res = rn - rm - {31'b0, cin}; m_c = exp_borrow(rn, rm, cin); end
        2'b10: begin m_res = rn - rm; m_c = exp_borrow(rn, rm, 1'b0); end
        2'b11: m_res = exp_clamp(rn);
        default: m_res = rn;
      endcase
      m_n = m_res[31];
      m_z = (m_res == 0);
    end
    @(posedge clk);
    #2;
    checks++;
    if (out_result !== m_res || out_n !== m_n || out_z !== m_z || out_c !== m_c) begin
      fails++;
      $display("FAIL %s: got res=%08h n=%0b z=%0b c=%0b, expected res=%08h n=%0b z=%0b c=%0b",
               tag, out_result, out_n, out_z, out_c, m_res, m_n, m_z, m_c);
    end
  endtask

  function automatic logic [31:0] pick_val();
    case ($urandom_range(0, 5))
      0: return 32'h0;
      1: return 32'hFFFFFFFF;
      2: return $urandom_range(0, 32'h1FFFF);
      3: return 32'h0000FFFF + $urandom_range(0, 2) - 1;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    #1;
    step(1, 0, 2'b00, 0, 0, 0);                         // R9 reset state
    step(0, 1, 2'b01, 32'h0, 32'h0, 1);                 // R1 R2: 0-0-1 wraps
    step(0, 1, 2'b01, 32'hFFFFFFFF, 32'hFFFFFFFF, 1);   // R1 R2: borrow + equal
    step(0, 1, 2'b10, 32'h5, 32'h3, 1);                 // R3: carry ignored
    step(0, 1, 2'b10, 32'h0, 32'h1, 0);                 // R3 R2 R4: negative
    step(0, 1, 2'b10, 32'h7, 32'h7, 1);                 // R3 R4: zero
    step(0, 1, 2'b11, 32'h80000000, 0, 0);              // R5 R6: negative clamps to 0
    step(0, 1, 2'b11, 32'h00010000, 0, 1);              // R5: above limit
    step(0, 1, 2'b11, 32'h0000FFFF, 0, 0);              // R5: at limit
    step(0, 1, 2'b11, 32'h00001234, 0, 0);              // R5: in range
    step(0, 1, 2'b10, 32'h0, 32'h1, 0);                 // set C
    step(0, 1, 2'b00, 32'h80000001, 0, 0);              // R7 R6: C kept
    step(0, 0, 2'b01, 32'h12345678, 32'h1, 1);          // R8 hold
    step(1, 1, 2'b01, 32'h0, 32'h1, 1);                 // R9 reset beats valid
    for (int i = 0; i < 3000; i++) begin
      step($urandom_range(0, 49) == 0, $urandom_range(0, 3) != 0,
           2'($urandom_range(0, 3)), pick_val(), pick_val(), 1'($urandom_range(0, 1)));
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule